// File: doc/BRIEF.md
# Byte Reverse and Bitfield Unit

A single-cycle 32-bit bit-manipulation unit for an integer datapath. It offers five fixed permutations of one operand (whole-word byte reversal, byte swap inside each 16-bit half, byte swap of the low half with sign extension, swap of the two halves, and full bit reversal). It also offers three field operations that take a start position and a field length: insert a field from a second operand into the first, and unsigned or signed extract of a field from the first operand.

Each request is presented with a valid strobe and is accepted every cycle. The result leaves through one register stage with its own valid flag, so back-to-back requests produce back-to-back results. A field that would run past bit 31 is shortened to fit; no other legality check is made.

Top module: `bitmanip_unit`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is 0 and `out_data` is 0.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and `out_data` is updated at that same edge. While `in_valid` is low, `out_data` keeps its last value.
- R3: Opcode 0 returns `src_a` with its four bytes in reverse order, so byte 3 becomes byte 0 and byte 0 becomes byte 3.
- R4: Opcode 1 exchanges the two bytes inside each 16-bit half of `src_a`, with the halves themselves left in place.
- R5: Opcode 2 exchanges the two bytes of the low half of `src_a` and sign-extends that 16-bit value into bits 31..16.
- R6: Opcode 3 exchanges the upper and lower 16-bit halves of `src_a`.
- R7: Opcode 4 returns `src_a` with bit i moved to bit 31-i.
- R8: Opcode 5 (insert) returns `(src_a & ~M) | ((src_b << pos) & M)`, where M has ones in bits pos to pos+L-1 and L is the effective length.
- R9: Opcode 6 (unsigned extract) returns bits pos to pos+L-1 of `src_a` in bits 0 to L-1, with zeros above.
- R10: Opcode 7 (signed extract) returns the same field as R9, with bit L-1 of the result copied into all higher bits.
- R11: The effective length L is the smaller of `width` and 32-`pos`. With L = 0 an insert returns `src_a` unchanged and both extracts return 0.
- R12: With `pos` 0 and a length of 32 or more, the mask is all ones: insert returns `src_b`, and both extracts return `src_a`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| op | input | 3 | Operation code (0 to 7, see R3 to R10) |
| src_a | input | 32 | Operand permuted or extracted from; destination for insert |
| src_b | input | 32 | Field source for insert |
| lsb | input | 5 | Field start position |
| width | input | 6 | Requested field length |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_data | output | 32 | Result |

## Verification
The result of one request leaves the output register at the same edge that captures the next request. An unbroken stream of mixed permutations and field operations is driven, with random positions and lengths, so that this hand-over happens at every edge. The scoreboard expects exactly one result per request, in order and with no gaps. After the stream, idle cycles are inserted and the bench checks that the last result stays on the output while `out_valid` is low.

// File: rtl/bmu_pkg.sv
// Shared operation codes for the bit-manipulation unit.
// Assumes the encoding is fixed by the instruction decoder upstream.
package bmu_pkg;
    typedef enum logic [2:0] {
        BMU_BREV32 = 3'd0,
        BMU_BREV16 = 3'd1,
        BMU_BREVSH = 3'd2,
        BMU_HSWAP  = 3'd3,
        BMU_BITREV = 3'd4,
        BMU_INSERT = 3'd5,
        BMU_UEXTR  = 3'd6,
        BMU_SEXTR  = 3'd7
    } bmu_op_e;
endpackage

// File: rtl/bmu_permute.sv
// Fixed permutations of one operand: byte, per-half byte, signed low-half,
// half swap and bit reversal. Assumes DATA_W is a multiple of 16, at least 32.
module bmu_permute
    import bmu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  bmu_op_e           op,
    input  logic [DATA_W-1:0] a,
    output logic [DATA_W-1:0] res
);
    localparam int NBYTES = DATA_W / 8;
    localparam int NHALVES = DATA_W / 16;
    localparam int HALF = DATA_W / 2;

    logic [DATA_W-1:0] byte_rev;
    logic [DATA_W-1:0] half_rev;
    logic [DATA_W-1:0] bit_rev;
    logic [DATA_W-1:0] half_swap;
    logic [DATA_W-1:0] sgn_rev;

    // Whole-word byte reversal.
    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        assign byte_rev[8*g +: 8] = a[8*(NBYTES-1-g) +: 8];
    end

    // Byte exchange inside each 16-bit half.
    for (genvar g = 0; g < NHALVES; g++) begin : g_half
        assign half_rev[16*g +: 16] = {a[16*g +: 8], a[16*g+8 +: 8]};
    end

    // Bit reversal.
    for (genvar g = 0; g < DATA_W; g++) begin : g_bit
        assign bit_rev[g] = a[DATA_W-1-g];
    end

    assign half_swap = {a[HALF-1:0], a[DATA_W-1:HALF]};
    assign sgn_rev   = {{(DATA_W-16){a[7]}}, a[7:0], a[15:8]};

    // Pick the permutation named by the opcode.
    always_comb begin
        case (op)
            BMU_BREV32: res = byte_rev;
            BMU_BREV16: res = half_rev;
            BMU_BREVSH: res = sgn_rev;
            BMU_HSWAP:  res = half_swap;
            BMU_BITREV: res = bit_rev;
            default:    res = '0;
        endcase
    end
endmodule

// File: rtl/bmu_mask_gen.sv
// Field mask builder. Clamps the requested length so the field ends at or
// below the top bit, and sets mask bits pos .. pos+len-1.
module bmu_mask_gen #(
    parameter  int DATA_W = 32,
    localparam int POS_W  = $clog2(DATA_W),
    localparam int LEN_W  = POS_W + 1
) (
    input  logic [POS_W-1:0]  lsb,
    input  logic [LEN_W-1:0]  len,
    output logic [LEN_W-1:0]  eff_len,
    output logic [DATA_W-1:0] mask
);
    logic [LEN_W-1:0] room;
    logic [LEN_W-1:0] pos_x;
    logic [LEN_W-1:0] end_pos;

    assign pos_x   = {1'b0, lsb};
    assign room    = LEN_W'(DATA_W) - pos_x;
    assign eff_len = (len > room) ? room : len;
    assign end_pos = pos_x + eff_len;

    // One comparator pair per mask bit.
    for (genvar g = 0; g < DATA_W; g++) begin : g_mask
        assign mask[g] = (LEN_W'(g) >= pos_x) && (LEN_W'(g) < end_pos);
    end
endmodule

// File: rtl/bmu_field.sv
// Field insert and extract. Expects a mask and clamped length from
// bmu_mask_gen; the field never crosses the top bit.
module bmu_field
    import bmu_pkg::*;
#(
    parameter  int DATA_W = 32,
    localparam int POS_W  = $clog2(DATA_W),
    localparam int LEN_W  = POS_W + 1
) (
    input  bmu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [POS_W-1:0]  lsb,
    input  logic [LEN_W-1:0]  eff_len,
    input  logic [DATA_W-1:0] mask,
    output logic [DATA_W-1:0] res
);
    logic [LEN_W-1:0]  up_sh;
    logic [LEN_W-1:0]  dn_sh;
    logic [DATA_W-1:0] ins_val;
    logic [DATA_W-1:0] uext_val;
    logic [DATA_W-1:0] lifted;
    logic [DATA_W-1:0] sext_val;

    assign up_sh    = LEN_W'(DATA_W) - {1'b0, lsb} - eff_len;
    assign dn_sh    = LEN_W'(DATA_W) - eff_len;
    assign ins_val  = (a & ~mask) | ((b << lsb) & mask);
    assign uext_val = (a & mask) >> lsb;
    assign lifted   = a << up_sh;
    assign sext_val = (eff_len == '0) ? '0 : $unsigned($signed(lifted) >>> dn_sh);

    // Pick the field result named by the opcode.
    always_comb begin
        case (op)
            BMU_INSERT: res = ins_val;
            BMU_UEXTR:  res = uext_val;
            BMU_SEXTR:  res = sext_val;
            default:    res = '0;
        endcase
    end
endmodule

// File: rtl/bitmanip_unit.sv
// Top of the bit-manipulation unit: permutation and field paths in parallel,
// one output register. Accepts a request every cycle; no back-pressure.
module bitmanip_unit
    import bmu_pkg::*;
#(
    parameter  int DATA_W = 32,
    localparam int POS_W  = $clog2(DATA_W),
    localparam int LEN_W  = POS_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        op,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [POS_W-1:0]  lsb,
    input  logic [LEN_W-1:0]  width,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    bmu_op_e           op_e;
    logic [DATA_W-1:0] perm_res;
    logic [DATA_W-1:0] field_res;
    logic [DATA_W-1:0] field_mask;
    logic [LEN_W-1:0]  eff_len;
    logic [DATA_W-1:0] next_data;
    logic              is_field;

    assign op_e     = bmu_op_e'(op);
    assign is_field = (op_e == BMU_INSERT) || (op_e == BMU_UEXTR) || (op_e == BMU_SEXTR);

    bmu_permute #(.DATA_W(DATA_W)) u_perm (
        .op  (op_e),
        .a   (src_a),
        .res (perm_res)
    );

    bmu_mask_gen #(.DATA_W(DATA_W)) u_mask (
        .lsb     (lsb),
        .len     (width),
        .eff_len (eff_len),
        .mask    (field_mask)
    );

    bmu_field #(.DATA_W(DATA_W)) u_field (
        .op      (op_e),
        .a       (src_a),
        .b       (src_b),
        .lsb     (lsb),
        .eff_len (eff_len),
        .mask    (field_mask),
        .res     (field_res)
    );

    assign next_data = is_field ? field_res : perm_res;

    // Output register: result and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_data <= next_data;
        end
    end
endmodule

// File: rtl/bmu_checker.sv
// Protocol and spot-function properties for bitmanip_unit, attached by bind.
module bmu_checker
    import bmu_pkg::*;
#(
    parameter  int DATA_W = 32,
    localparam int POS_W  = $clog2(DATA_W),
    localparam int LEN_W  = POS_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [2:0]        op,
    input logic [DATA_W-1:0] src_a,
    input logic [LEN_W-1:0]  width,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data
);
    localparam int NBYTES = DATA_W / 8;
    localparam int HALF = DATA_W / 2;

    logic [DATA_W-1:0] ref_brev;
    logic [DATA_W-1:0] ref_bitrev;

    // Independent reversal references for the properties below.
    always_comb begin
        for (int i = 0; i < NBYTES; i++) ref_brev[8*i +: 8] = src_a[8*(NBYTES-1-i) +: 8];
        for (int i = 0; i < DATA_W; i++) ref_bitrev[i] = src_a[DATA_W-1-i];
    end

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_data)));
    a_r3_byte_reverse: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == BMU_BREV32) |=> out_data == $past(ref_brev));
    a_r5_sign_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == BMU_BREVSH) |=> out_data[DATA_W-1:16] == {(DATA_W-16){out_data[15]}});
    a_r6_half_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == BMU_HSWAP) |=>
        out_data == {$past(src_a[HALF-1:0]), $past(src_a[DATA_W-1:HALF])});
    a_r7_bit_reverse: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == BMU_BITREV) |=> out_data == $past(ref_bitrev));
    a_r11_empty_insert: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == BMU_INSERT && width == '0) |=> out_data == $past(src_a));
    a_r11_empty_extract: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == BMU_UEXTR || op == BMU_SEXTR) && width == '0) |=> out_data == '0);
endmodule

bind bitmanip_unit bmu_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .src_a     (src_a),
    .width     (width),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/sim_bitmanip_unit.sv
// Scoreboard bench: driver queues expected results, monitor compares.
module sim_bitmanip_unit;
    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [4:0]  lsb = '0;
    logic [5:0]  width = '0;
    logic        out_valid;
    logic [31:0] out_data;

    item_t       sb[$];
    int          n_checks = 0;
    int          n_fail = 0;
    logic [31:0] last_exp = '0;

    always #5 clk = ~clk;

    bitmanip_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .src_a(src_a), .src_b(src_b), .lsb(lsb), .width(width),
        .out_valid(out_valid), .out_data(out_data)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Reference model written from the requirements.
    function automatic logic [31:0] model(int o, logic [31:0] a, logic [31:0] b, int p, int w);
        logic [31:0] r;
        int eff;
        eff = (w > 32 - p) ? 32 - p : w;
        r = '0;
        case (o)
            0: r = {a[7:0], a[15:8], a[23:16], a[31:24]};
            1: r = {a[23:16], a[31:24], a[7:0], a[15:8]};
            2: r = {{16{a[7]}}, a[7:0], a[15:8]};
            3: r = {a[15:0], a[31:16]};
            4: for (int i = 0; i < 32; i++) r[i] = a[31-i];
            5: begin
                r = a;
                for (int i = 0; i < eff; i++) r[p+i] = b[i];
            end
            default: begin
                for (int i = 0; i < eff; i++) r[i] = a[p+i];
                if (o == 7 && eff > 0 && r[eff-1])
                    for (int i = eff; i < 32; i++) r[i] = 1'b1;
            end
        endcase
        return r;
    endfunction

    function automatic string op_tag(int o);
        case (o)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            3: return "R6";
            4: return "R7";
            5: return "R8";
            6: return "R9";
            default: return "R10";
        endcase
    endfunction

    // Driver: apply one request at a falling edge and queue its result.
    task automatic send(int o, logic [31:0] a, logic [31:0] b, int p, int w, string tag);
        item_t it;
        @(negedge clk);
        in_valid = 1'b1;
        op = 3'(o);
        src_a = a;
        src_b = b;
        lsb = 5'(p);
        width = 6'(w);
        it.exp = model(o, a, b, p, w);
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: compare each result, in order, away from the rising edge.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && out_valid) begin
                if (sb.size() == 0) begin
                    check("R2 unexpected result", out_valid, 1'b0);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    check(it.tag, out_data, it.exp);
                    last_exp = it.exp;
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R2 watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 out_valid", {31'b0, out_valid}, 32'h0);
        check("R1 out_data", out_data, 32'h0);

        send(0, 32'h11223344, 0, 0, 0, "R3");
        send(1, 32'h11223344, 0, 0, 0, "R4");
        send(2, 32'h000080FF, 0, 0, 0, "R5 negative");
        send(2, 32'hABCD1234, 0, 0, 0, "R5 positive");
        send(3, 32'h12345678, 0, 0, 0, "R6");
        send(4, 32'h00000001, 0, 0, 0, "R7");
        send(4, 32'h0000000F, 0, 0, 0, "R7");
        send(5, 32'hFFFFFFFF, 32'h0, 8, 4, "R8");
        send(5, 32'h00000000, 32'h5, 12, 3, "R8");
        send(6, 32'hABCD1234, 0, 4, 8, "R9");
        send(7, 32'h00000F00, 0, 8, 4, "R10 negative");
        send(7, 32'h00000700, 0, 8, 4, "R10 positive");
        send(5, 32'h00000000, 32'h000000FF, 28, 8, "R11 clamp insert");
        send(7, 32'h80000000, 0, 31, 5, "R11 clamp signed");
        send(5, 32'hDEADBEEF, 32'h12345678, 4, 0, "R11 empty insert");
        send(7, 32'hFFFFFFFF, 0, 3, 0, "R11 empty signed");
        send(6, 32'hFFFFFFFF, 0, 3, 0, "R11 empty unsigned");
        send(5, 32'hDEADBEEF, 32'h12345678, 0, 32, "R12 full insert");
        send(7, 32'h87654321, 0, 0, 32, "R12 full signed");
        send(6, 32'h87654321, 0, 0, 40, "R12 full unsigned");
        idle(2);
        check("R2 idle hold", out_data, last_exp);
        check("R2 idle valid", {31'b0, out_valid}, 32'h0);

        for (int n = 0; n < 300; n++) begin
            int o;
            o = int'($urandom % 8);
            send(o, $urandom, $urandom, int'($urandom % 32), int'($urandom % 64), op_tag(o));
            if (n % 50 == 49) idle(1);
        end
        idle(3);
        check("R2 queue drained", sb.size(), 0);
        check("R2 final hold", out_data, last_exp);
        finish_run();
    end
endmodule